// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block turns the address bus and the active-low control strobes of a small 8-bit processor into the select and strobe lines for a program ROM and a large banked SRAM. The 64K address space is cut into eight 8K regions. A parameter table gives each region a kind: ROM, flat SRAM, banked SRAM or unmapped. A 5-bit page register supplies the upper SRAM address bits whenever a banked region is accessed. With the default table, the 32K–48K window is banked as 32 pages of 16K. The 8K–32K area is ordinary flat SRAM, and 48K–64K is left unmapped.

All chip-side outputs are active-low and are formed combinationally from the bus inputs. The ROM select is asserted by default and is only withdrawn when a memory request targets a region mapped to something else, so ROM access never waits on decode delay. Writing the page register is a plain memory write to a fixed address inside the ROM region, and that write withdraws the ROM select. The SRAM output enable follows the read strobe and not the address decode, so the SRAM never fights the processor for the data bus during a write. A write-protect switch input and a power-fail input each block every SRAM write. Power-fail also clears the page register.

Top module: `paged_mem_decoder`

## Requirements
- R1: The region is addr[15:13]. Its kind is the 2-bit field REGION_MAP[2*region+1 : 2*region], with code 0 meaning ROM, 1 flat SRAM, 2 banked SRAM and 3 unmapped. The default map is 16'hFA54: region 0 is ROM, regions 1–3 are flat, regions 4–5 are banked and regions 6–7 are unmapped.
- R2: While mreq_n is high, ram_cs_n and ram_we_n are high and rom_cs_n is low, whatever the address.
- R3: rom_cs_n is low unless one of two things holds. Either mreq_n is low and the region kind is not ROM, or a page write is in progress (mreq_n low, wr_n low, addr equal to PAGE_ADDR, default 16'h1FFF). In either case rom_cs_n is high.
- R4: ram_cs_n is low exactly when mreq_n is low and the region kind is 1 or 2.
- R5: ram_oe_n is low exactly when rd_n is low and rfsh_n is high (the refresh qualifier is enabled by default). It does not depend on the address or on mreq_n.
- R6: ram_we_n is low exactly when ram_cs_n is low, wr_n is low, wprot is low and pwr_fail is low.
- R7: A page write captures data_in[4:0]. The new page is visible on the second rising clock edge after the write begins, that is, on the edge that samples wr_n high again. The page is 0 after rst.
- R8: ram_addr has 19 bits. For a flat region it is {3'b111, addr[15:0]}. Otherwise it is {page, addr[13:0]}.
- R9: While pwr_fail is high, the next clock edge clears the page to 0 and discards any pending page write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| data_in | input | 8 | Processor data bus, used for page writes |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh cycle indicator, active low |
| wprot | input | 1 | Hardware write-protect switch, active high |
| pwr_fail | input | 1 | Under-voltage indication, active high |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | SRAM chip select, active low |
| ram_oe_n | output | 1 | SRAM output enable, active low |
| ram_we_n | output | 1 | SRAM write enable, active low |
| ram_addr | output | 19 | SRAM address including page bits |

## Verification
The assertions assume a well-formed bus. rd_n and wr_n are never low together, and a page write holds its address for one clock with wr_n low before wr_n returns high. Under these assumptions the output enable and the write enable can never be active at the same time. The random stimulus only draws legal cycle types: idle, memory read, memory write, refresh, and I/O read or write. It also steers random addresses away from the page register address, so only directed sequences touch the page. Write-protect and power-fail are toggled randomly across all of these cycles.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    typedef enum logic [1:0] {
        RK_ROM       = 2'd0,
        RK_RAM_FLAT  = 2'd1,
        RK_RAM_BANK  = 2'd2,
        RK_NONE      = 2'd3
    } region_kind_e;

    // bus strobes converted to active-high
    typedef struct packed {
        logic mreq;
        logic rd;
        logic wr;
        logic rfsh;
    } bus_ctl_t;

    // result of the address decode
    typedef struct packed {
        logic         rom_region;
        logic         ram_region;
        logic         flat_region;
        logic         page_hit;
        region_kind_e kind;
    } decode_t;

    function automatic region_kind_e kind_of(input logic [15:0] map,
                                             input logic [2:0]  region);
        return region_kind_e'(map[{region, 1'b0} +: 2]);
    endfunction

    function automatic bus_ctl_t ctl_from_pins(input logic mreq_n, input logic rd_n,
                                               input logic wr_n, input logic rfsh_n);
        bus_ctl_t c;
        c.mreq = ~mreq_n;
        c.rd   = ~rd_n;
        c.wr   = ~wr_n;
        c.rfsh = ~rfsh_n;
        return c;
    endfunction

endpackage

// File: rtl/pmd_region_dec.sv
module pmd_region_dec
    import pmd_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          REG_BITS   = 3,
    parameter logic [15:0] REGION_MAP = 16'hFA54,
    parameter logic [15:0] PAGE_ADDR  = 16'h1FFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  bus_ctl_t          ctl,
    output decode_t           dec
);
    localparam int N_REG = 1 << REG_BITS;

    logic [REG_BITS-1:0] region;
    logic [N_REG-1:0]    hit;
    logic [N_REG-1:0]    is_rom;
    logic [N_REG-1:0]    is_ram;
    logic [N_REG-1:0]    is_flat;
    region_kind_e        kinds [N_REG];

    assign region = addr[ADDR_W-1 -: REG_BITS];

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        assign kinds[r]   = kind_of(REGION_MAP, 3'(r));
        assign hit[r]     = (region == REG_BITS'(r));
        assign is_rom[r]  = (kinds[r] == RK_ROM);
        assign is_flat[r] = (kinds[r] == RK_RAM_FLAT);
        assign is_ram[r]  = (kinds[r] == RK_RAM_FLAT) || (kinds[r] == RK_RAM_BANK);
    end

    always_comb begin
        dec.kind        = kinds[region];
        dec.rom_region  = |(hit & is_rom);
        dec.ram_region  = |(hit & is_ram);
        dec.flat_region = |(hit & is_flat);
        dec.page_hit    = ctl.mreq && ctl.wr && (addr == PAGE_ADDR);
    end

endmodule

// File: rtl/pmd_page_reg.sv
module pmd_page_reg #(
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_fail,
    input  logic              page_hit,
    input  logic              wr_active,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page,
    output logic              pending
);
    logic [PAGE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || pwr_fail) begin
            page    <= '0;
            hold_q  <= '0;
            pending <= 1'b0;
        end else if (page_hit) begin
            hold_q  <= wdata;
            pending <= 1'b1;
        end else if (pending && !wr_active) begin
            page    <= hold_q;
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/pmd_addr_map.sv
module pmd_addr_map #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 5,
    parameter int WIN_BITS = 14
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [PAGE_W-1:0]          page,
    input  logic                       flat,
    output logic [PAGE_W+WIN_BITS-1:0] ram_addr
);
    localparam int RAM_AW   = PAGE_W + WIN_BITS;
    localparam int FLAT_PAD = RAM_AW - ADDR_W;

    logic [RAM_AW-1:0] banked_a;
    logic [RAM_AW-1:0] flat_a;

    assign banked_a = {page, addr[WIN_BITS-1:0]};
    assign flat_a   = {{FLAT_PAD{1'b1}}, addr};
    assign ram_addr = flat ? flat_a : banked_a;

endmodule

// File: rtl/pmd_strobe_gen.sv
module pmd_strobe_gen
    import pmd_pkg::*;
#(
    parameter bit OE_RFSH_QUAL = 1'b1
) (
    input  decode_t  dec,
    input  bus_ctl_t ctl,
    input  logic     wprot,
    input  logic     pwr_fail,
    output logic     rom_cs_n,
    output logic     ram_cs_n,
    output logic     ram_oe_n,
    output logic     ram_we_n
);
    logic rom_drop;
    logic ram_sel;
    logic oe_ok;
    logic we_ok;

    always_comb begin
        rom_drop = (ctl.mreq && !dec.rom_region) || dec.page_hit;
        ram_sel  = ctl.mreq && dec.ram_region;
        oe_ok    = ctl.rd && (!OE_RFSH_QUAL || !ctl.rfsh);
        we_ok    = ram_sel && ctl.wr && !wprot && !pwr_fail;
        rom_cs_n = rom_drop;
        ram_cs_n = !ram_sel;
        ram_oe_n = !oe_ok;
        ram_we_n = !we_ok;
    end

endmodule

// File: rtl/paged_mem_decoder.sv
module paged_mem_decoder
    import pmd_pkg::*;
#(
    parameter int          DATA_W       = 8,
    parameter int          PAGE_W       = 5,
    parameter int          WIN_BITS     = 14,
    parameter logic [15:0] REGION_MAP   = 16'hFA54,
    parameter logic [15:0] PAGE_ADDR    = 16'h1FFF,
    parameter bit          OE_RFSH_QUAL = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [15:0]                addr,
    input  logic [DATA_W-1:0]          data_in,
    input  logic                       mreq_n,
    input  logic                       rd_n,
    input  logic                       wr_n,
    input  logic                       rfsh_n,
    input  logic                       wprot,
    input  logic                       pwr_fail,
    output logic                       rom_cs_n,
    output logic                       ram_cs_n,
    output logic                       ram_oe_n,
    output logic                       ram_we_n,
    output logic [PAGE_W+WIN_BITS-1:0] ram_addr
);
    localparam int ADDR_W   = 16;
    localparam int REG_BITS = 3;

    bus_ctl_t          ctl;
    decode_t           dec;
    logic [PAGE_W-1:0] page_cur;
    logic              page_pend;
    logic              unused_hi;

    assign ctl       = ctl_from_pins(mreq_n, rd_n, wr_n, rfsh_n);
    assign unused_hi = ^data_in[DATA_W-1:PAGE_W];

    pmd_region_dec #(
        .ADDR_W     (ADDR_W),
        .REG_BITS   (REG_BITS),
        .REGION_MAP (REGION_MAP),
        .PAGE_ADDR  (PAGE_ADDR)
    ) u_dec (
        .addr (addr),
        .ctl  (ctl),
        .dec  (dec)
    );

    pmd_page_reg #(
        .PAGE_W (PAGE_W)
    ) u_page (
        .clk       (clk),
        .rst       (rst),
        .pwr_fail  (pwr_fail),
        .page_hit  (dec.page_hit),
        .wr_active (ctl.wr),
        .wdata     (data_in[PAGE_W-1:0]),
        .page      (page_cur),
        .pending   (page_pend)
    );

    pmd_addr_map #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .WIN_BITS (WIN_BITS)
    ) u_amap (
        .addr     (addr),
        .page     (page_cur),
        .flat     (dec.flat_region),
        .ram_addr (ram_addr)
    );

    pmd_strobe_gen #(
        .OE_RFSH_QUAL (OE_RFSH_QUAL)
    ) u_strb (
        .dec      (dec),
        .ctl      (ctl),
        .wprot    (wprot),
        .pwr_fail (pwr_fail),
        .rom_cs_n (rom_cs_n),
        .ram_cs_n (ram_cs_n),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n)
    );

endmodule

// File: rtl/paged_mem_decoder_chk.sv
module paged_mem_decoder_chk #(
    parameter int          PAGE_W    = 5,
    parameter logic [15:0] PAGE_ADDR = 16'h1FFF
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       addr,
    input logic              mreq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              wprot,
    input logic              pwr_fail,
    input logic              rom_cs_n,
    input logic              ram_cs_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [PAGE_W-1:0] page_cur,
    input logic              page_pend
);
    // R2: no SRAM activity without a memory request
    a_r2_idle_no_ram: assert property (@(posedge clk) disable iff (rst)
        mreq_n |-> (ram_cs_n && ram_we_n && !rom_cs_n));

    // R3: a page write never selects the ROM
    a_r3_page_wr_rom_off: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && !wr_n && addr == PAGE_ADDR) |-> rom_cs_n);

    // R4: ROM and SRAM are never selected together
    a_r4_rom_ram_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rom_cs_n && !ram_cs_n));

    // R5: output enable only during a read
    a_r5_oe_needs_rd: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> !rd_n);

    // R5 and R6: no bus fight on a legal bus
    a_r6_no_oe_we_overlap: assert property (@(posedge clk) disable iff (rst)
        (rd_n || wr_n) |-> !(!ram_oe_n && !ram_we_n));

    // R6: write enable implies SRAM select
    a_r6_we_needs_cs: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !ram_cs_n);

    // R6: write protect blocks every SRAM write
    a_r6_wprot_blocks: assert property (@(posedge clk) disable iff (rst)
        wprot |-> ram_we_n);

    // R9: power fail blocks writes and clears the page
    a_r9_pf_blocks_we: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |-> ram_we_n);

    a_r9_pf_clears_page: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (page_cur == '0 && !page_pend));

    // R7: the page only moves when a pending write commits
    a_r7_page_holds: assert property (@(posedge clk) disable iff (rst)
        (!page_pend && !pwr_fail) |=> $stable(page_cur));

endmodule

bind paged_mem_decoder paged_mem_decoder_chk #(
    .PAGE_W    (PAGE_W),
    .PAGE_ADDR (PAGE_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .wprot     (wprot),
    .pwr_fail  (pwr_fail),
    .rom_cs_n  (rom_cs_n),
    .ram_cs_n  (ram_cs_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .page_cur  (page_cur),
    .page_pend (page_pend)
);

// File: tb/tb_paged_mem_decoder.sv
module tb_paged_mem_decoder;
    localparam logic [15:0] MAP   = 16'hFA54;
    localparam logic [15:0] PADDR = 16'h1FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
    logic        wprot = 1'b0, pwr_fail = 1'b0;
    logic        rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n;
    logic [18:0] ram_addr;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic [4:0] page_m = '0;

    always #2 clk = ~clk;

    paged_mem_decoder dut (
        .clk(clk), .rst(rst), .addr(addr), .data_in(data_in),
        .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n),
        .wprot(wprot), .pwr_fail(pwr_fail),
        .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_addr(ram_addr)
    );

    function automatic logic [1:0] kind_m(input logic [15:0] a);
        return MAP[{a[15:13], 1'b0} +: 2];
    endfunction

    // expected {rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n}
    function automatic logic [3:0] exp_strobes(input logic [15:0] a);
        logic mr, pg, ramk, rom, rcs, oe, we;
        mr   = !mreq_n;
        pg   = mr && !wr_n && (a == PADDR);
        ramk = (kind_m(a) == 2'd1) || (kind_m(a) == 2'd2);
        rom  = !((mr && kind_m(a) != 2'd0) || pg);
        rcs  = mr && ramk;
        oe   = !rd_n && rfsh_n;
        we   = rcs && !wr_n && !wprot && !pwr_fail;
        return {!rom, !rcs, !oe, !we};
    endfunction

    function automatic logic [18:0] exp_addr(input logic [15:0] a);
        if (kind_m(a) == 2'd1) return {3'b111, a};
        return {page_m, a[13:0]};
    endfunction

    task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, {rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n, ram_addr},
                   {exp_strobes(addr), exp_addr(addr)});
    endtask

    task automatic bus(input logic [15:0] a, input logic m, input logic r,
                       input logic w, input logic f);
        addr = a; mreq_n = m; rd_n = r; wr_n = w; rfsh_n = f;
    endtask

    // page write: wr low over one edge, then high over the next (R7)
    task automatic page_write(input logic [7:0] d);
        @(negedge clk);
        bus(PADDR, 1'b0, 1'b1, 1'b0, 1'b1);
        data_in = d;
        #1 check("R3 page write drops ROM", {22'b0, rom_cs_n}, 23'd1);
        @(negedge clk);
        bus(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        page_m = d[4:0];
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R7 reset state", {rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n, ram_addr},
                 {4'b0111, 5'd0, 14'd0});
        rst = 1'b0;

        // R1 R4 R8: each region read, default page 0
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            bus({r[2:0], 13'h0155}, 1'b0, 1'b0, 1'b1, 1'b1);
            #1 check_all("R1 R4 R8 region read");
        end

        // R2: idle bus in an SRAM region
        @(negedge clk); bus(16'h4000, 1'b1, 1'b1, 1'b1, 1'b1);
        #1 check("R2 idle", {19'd0, rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n}, {19'd0, 4'b0111});

        // R5: read outside any memory request still enables SRAM output
        @(negedge clk); bus(16'hE000, 1'b1, 1'b0, 1'b1, 1'b1);
        #1 check("R5 oe from rd", {22'd0, ram_oe_n}, 23'd0);
        // R5: refresh qualifier removes the output enable
        @(negedge clk); bus(16'h8000, 1'b0, 1'b0, 1'b1, 1'b0);
        #1 check("R5 oe qualified by rfsh", {22'd0, ram_oe_n}, 23'd1);

        // R6: write, with and without protection
        @(negedge clk); bus(16'h2000, 1'b0, 1'b1, 1'b0, 1'b1);
        #1 check("R6 write enabled", {22'd0, ram_we_n}, 23'd0);
        wprot = 1'b1;
        #1 check("R6 wprot blocks", {22'd0, ram_we_n}, 23'd1);
        wprot = 1'b0;
        // R6: write to a ROM region gives no SRAM write
        @(negedge clk); bus(16'h0100, 1'b0, 1'b1, 1'b0, 1'b1);
        #1 check("R6 rom write", {21'd0, ram_cs_n, ram_we_n}, {21'd0, 2'b11});

        // R7 R8: page writes move the banked window
        page_write(8'hF3);
        @(negedge clk); bus(16'hA123, 1'b0, 1'b0, 1'b1, 1'b1);
        #1 check("R7 R8 page 19 bank addr", {4'd0, ram_addr}, {4'd0, 5'd19, 14'h2123});
        page_write(8'h1F);
        @(negedge clk); bus(16'h8001, 1'b0, 1'b0, 1'b1, 1'b1);
        #1 check("R7 R8 page 31 bank addr", {4'd0, ram_addr}, {4'd0, 5'd31, 14'h0001});
        @(negedge clk); bus(16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1);
        #1 check("R8 flat addr ignores page", {4'd0, ram_addr}, {4'd0, 19'h77FFF});

        // R9: power fail during a pending page write
        page_write(8'h05);
        @(negedge clk);
        bus(PADDR, 1'b0, 1'b1, 1'b0, 1'b1); data_in = 8'h0A;
        @(negedge clk);
        bus(16'h4000, 1'b0, 1'b1, 1'b0, 1'b1); pwr_fail = 1'b1;
        @(negedge clk);
        page_m = 5'd0;
        #1 check("R9 pf blocks we", {22'd0, ram_we_n}, 23'd1);
        pwr_fail = 1'b0;
        bus(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        bus(16'h9000, 1'b0, 1'b0, 1'b1, 1'b1);
        #1 check("R9 page cleared, pending dropped", {4'd0, ram_addr}, {4'd0, 5'd0, 14'h1000});

        page_write(8'h0C);

        // random legal cycles
        void'($urandom(32'd4711));
        for (int i = 0; i < 4000; i++) begin
            int kind;
            logic [15:0] a;
            @(negedge clk);
            kind = $urandom_range(0, 5);
            a = 16'($urandom);
            if (a == PADDR) a = a ^ 16'h0001;
            wprot    = ($urandom_range(0, 3) == 0);
            pwr_fail = ($urandom_range(0, 15) == 0);
            data_in  = 8'($urandom);
            case (kind)
                0: bus(a, 1'b1, 1'b1, 1'b1, 1'b1);
                1: bus(a, 1'b0, 1'b0, 1'b1, 1'b1);
                2: bus(a, 1'b0, 1'b1, 1'b0, 1'b1);
                3: bus(a, 1'b0, 1'b1, 1'b1, 1'b0);
                4: bus(a, 1'b1, 1'b0, 1'b1, 1'b1);
                default: bus(a, 1'b1, 1'b1, 1'b0, 1'b1);
            endcase
            #1 check_all("R1-R6 R8 random");
            if (pwr_fail) page_m = 5'd0;
        end

        @(negedge clk);
        pwr_fail = 1'b0; wprot = 1'b0;
        bus(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule